// File: doc/BRIEF.md
# Register-Mapped Character Port with Byte DMA

This block is a 32-bit register-mapped character port. Software reaches it through a word-addressed slave interface. Characters leave on a byte stream with valid/ready handshaking. Characters arrive on a second byte stream, which the block back-pressures when it has no room. A receive FIFO holds incoming characters until software pops them. A byte-wide memory master moves data without the processor: it fetches outgoing bytes for a transmit DMA and stores incoming bytes for a receive DMA. A single level-sensitive interrupt reports three conditions, each gated by an enable bit.

Software starts a transmit DMA by setting a source address and then writing a byte count. Software starts a receive DMA by setting a destination address and then writing a count. The block first empties the FIFO into memory, up to that count. Any count that remains after that is served straight from the receive stream: those bytes go to memory without passing through the FIFO. While a DMA sequence is running, every register access is held off with a wait signal.

Top module: `serial_dma_port`

## Requirements
- R1: The register index is `bus_addr[11:2]`. Index 0 reads the constant 0xC51D0001. Index 5 (transmit count) always reads 0. Any index above 7 reads 0.
- R2: A read of index 1 returns the oldest FIFO byte, zero-extended, and removes it. When the FIFO is empty, the read returns 0xFFFFFFFF and nothing is removed.
- R3: A write to index 1 places bits [7:0] of the written word on `tx_data` with `tx_valid` high. The byte is held stable until `tx_ready` takes it.
- R4: Index 2 reads the FIFO occupancy (16 entries by default). While the remaining receive count is zero, `rx_ready` is high exactly when the FIFO has a free slot, so no byte is taken when the FIFO is full.
- R5: A write to index 3 keeps only bits [2:0] as the interrupt enable, and a read of index 3 returns them.
- R6: The status word has three bits: bit 0 is high when the FIFO is not empty, bit 1 is always high, and bit 2 is high when the remaining receive count is zero. One cycle after any state, `irq` equals the OR of (status AND enable) for that state.
- R7: A write of N to index 5 reads N bytes from memory. It starts at the address held in index 4 and sends the bytes on the transmit stream in ascending address order. Index 4 then reads the start address plus N. N = 0 sends nothing.
- R8: A write of N to index 7 stores min(N, occupancy) FIFO bytes, oldest first, to ascending memory addresses starting at index 6. Index 7 then reads N minus the number stored, and index 6 reads the start address plus the number stored.
- R9: While the remaining receive count is nonzero, each received byte is written to memory at index 6. The address then increases by one and the count decreases by one, and the FIFO is left unchanged.
- R10: While a DMA sequence is active, every register access sees `bus_wait` high. The access completes once the sequence ends. A write to index 1 also waits while the previous byte is still unaccepted.
- R11: After synchronous reset the following hold:
  - The enable, both addresses and the receive count read 0, and the FIFO is empty.
  - `irq`, `tx_valid` and `mem_req` are low.
- R12: A memory request holds `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, held until accepted |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits [11:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after acceptance |
| bus_wait | output | 1 | Access stalled this cycle |
| tx_data | output | 8 | Outgoing character |
| tx_valid | output | 1 | Outgoing character present |
| tx_ready | input | 1 | Sink accepts the character |
| rx_data | input | 8 | Incoming character |
| rx_valid | input | 1 | Incoming character present |
| rx_ready | output | 1 | Block accepts the incoming character |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Byte to store |
| mem_rdata | input | 8 | Fetched byte, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the request this cycle |
| irq | output | 1 | Level interrupt |

## Verification
The bench fills the FIFO to its exact depth and offers one more byte. A design with an off-by-one full flag would take the byte and lose data. It then starts a receive DMA whose count is both smaller and larger than the occupancy. A wrong drain limit shows up as a bad remaining count, a bad address or misplaced memory bytes. Once the FIFO is empty, bytes must bypass it until the count runs out and then return to it; a design that kept pushing would report a nonzero FIFO count. Transmit DMA runs under random memory and sink stalls, with a register access raised immediately after the start, so a missing wait or a dropped byte during a stall breaks the order or address checks. A zero-length transmit must send nothing.

// File: rtl/serial_dma_pkg.sv
package serial_dma_pkg;
  localparam logic [31:0] PORT_ID = 32'hC51D0001;

  localparam int IX_ID   = 0;
  localparam int IX_DATA = 1;
  localparam int IX_FCNT = 2;
  localparam int IX_IEN  = 3;
  localparam int IX_TXA  = 4;
  localparam int IX_TXN  = 5;
  localparam int IX_RXA  = 6;
  localparam int IX_RXN  = 7;

  localparam int STAT_W = 3;

  typedef enum logic [1:0] {
    ENG_IDLE   = 2'd0,
    ENG_TX     = 2'd1,
    ENG_DRAIN  = 2'd2,
    ENG_DIRECT = 2'd3
  } eng_state_e;
endpackage

// File: rtl/sdp_fifo.sv
module sdp_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) store[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= step(wr_q);
      if (pop)  rd_q <= step(rd_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = store[rd_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/sdp_dma.sv
module sdp_dma
  import serial_dma_pkg::*;
#(
  parameter int MEM_AW = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_txa,
  input  logic              wr_txn,
  input  logic              wr_rxa,
  input  logic              wr_rxn,
  input  logic              wr_data,
  input  logic [31:0]       wdata,
  input  logic              bus_active,
  input  logic              f_empty,
  input  logic              f_full,
  input  logic [7:0]        f_head,
  output logic              f_push,
  output logic [7:0]        f_din,
  output logic              f_pop,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  output logic              busy,
  output logic [MEM_AW-1:0] tx_addr,
  output logic [MEM_AW-1:0] rx_addr,
  output logic [CNT_W-1:0]  rx_left
);
  eng_state_e        state_q;
  logic [CNT_W-1:0]  tx_left_q;
  logic [7:0]        hold_q;
  logic              ack, direct_ok, take_direct, rx_fifo_mode;

  assign ack          = mem_req && mem_ack;
  assign rx_fifo_mode = (rx_left == '0);
  assign direct_ok    = !rx_fifo_mode && (state_q == ENG_IDLE) && !bus_active;
  assign rx_ready     = rx_fifo_mode ? !f_full : direct_ok;
  assign take_direct  = rx_valid && direct_ok;
  assign f_push       = rx_valid && rx_fifo_mode && !f_full;
  assign f_din        = rx_data;
  assign f_pop        = (state_q == ENG_DRAIN) && ack;
  assign busy         = (state_q != ENG_IDLE);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = rx_addr;
    mem_wdata = hold_q;
    unique case (state_q)
      ENG_TX: begin
        mem_req  = !tx_valid;
        mem_addr = tx_addr;
      end
      ENG_DRAIN: begin
        mem_req   = !rx_fifo_mode && !f_empty;
        mem_we    = 1'b1;
        mem_wdata = f_head;
      end
      ENG_DIRECT: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ENG_IDLE;
      tx_left_q <= '0;
      hold_q    <= '0;
      tx_addr   <= '0;
      rx_addr   <= '0;
      rx_left   <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
    end else begin
      if (tx_valid && tx_ready) tx_valid <= 1'b0;
      if (wr_data) begin
        tx_valid <= 1'b1;
        tx_data  <= wdata[7:0];
      end
      if (wr_txa) tx_addr <= wdata[MEM_AW-1:0];
      if (wr_rxa) rx_addr <= wdata[MEM_AW-1:0];
      unique case (state_q)
        ENG_IDLE: begin
          if (wr_txn && (wdata[CNT_W-1:0] != '0)) begin
            tx_left_q <= wdata[CNT_W-1:0];
            state_q   <= ENG_TX;
          end else if (wr_rxn) begin
            rx_left <= wdata[CNT_W-1:0];
            state_q <= ENG_DRAIN;
          end else if (take_direct) begin
            hold_q  <= rx_data;
            state_q <= ENG_DIRECT;
          end
        end
        ENG_TX: begin
          if (ack) begin
            tx_data   <= mem_rdata;
            tx_valid  <= 1'b1;
            tx_addr   <= tx_addr + 1'b1;
            tx_left_q <= tx_left_q - 1'b1;
            if (tx_left_q == CNT_W'(1)) state_q <= ENG_IDLE;
          end
        end
        ENG_DRAIN: begin
          if (ack) begin
            rx_addr <= rx_addr + 1'b1;
            rx_left <= rx_left - 1'b1;
          end else if (rx_fifo_mode || f_empty) begin
            state_q <= ENG_IDLE;
          end
        end
        ENG_DIRECT: begin
          if (ack) begin
            rx_addr <= rx_addr + 1'b1;
            rx_left <= rx_left - 1'b1;
            state_q <= ENG_IDLE;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  a_r12_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  a_r3_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  a_r9_bypass_fifo: assert property (@(posedge clk) disable iff (rst)
    (rx_left != '0) |-> !f_push);
  a_r7_tx_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !mem_we) |=> (tx_addr == $past(tx_addr) + 1'b1));
endmodule

// File: rtl/sdp_irq.sv
module sdp_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] status,
  input  logic [N-1:0] enable,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & enable);
  end

  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (enable == '0) |=> !irq);
endmodule

// File: rtl/serial_dma_port.sv
module serial_dma_port
  import serial_dma_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int BUS_AW     = 12,
  parameter int MEM_AW     = 32,
  parameter int CNT_W      = 32,
  localparam int IXW       = BUS_AW - 2,
  localparam int FCW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_wait,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  output logic              irq
);
  logic [IXW-1:0]    idx;
  logic              acc, rd_acc, wr_acc, eng_busy;
  logic              f_push, f_pop, f_pop_eng, f_pop_bus, f_full, f_empty;
  logic [7:0]        f_din, f_head;
  logic [FCW-1:0]    f_count;
  logic [MEM_AW-1:0] tx_addr, rx_addr;
  logic [CNT_W-1:0]  rx_left;
  logic [STAT_W-1:0] ien_q, status;
  logic [31:0]       rd_val;
  logic              unused_addr_lsb;

  assign unused_addr_lsb = ^bus_addr[1:0];
  assign idx      = bus_addr[BUS_AW-1:2];
  assign bus_wait = bus_req && (eng_busy ||
                    (bus_we && (idx == IXW'(IX_DATA)) && tx_valid));
  assign acc      = bus_req && !bus_wait;
  assign rd_acc   = acc && !bus_we;
  assign wr_acc   = acc && bus_we;

  assign f_pop_bus = rd_acc && (idx == IXW'(IX_DATA)) && !f_empty;
  assign f_pop     = f_pop_bus || f_pop_eng;

  sdp_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk, .rst,
    .push(f_push), .din(f_din), .pop(f_pop), .dout(f_head),
    .full(f_full), .empty(f_empty), .count(f_count)
  );

  sdp_dma #(.MEM_AW(MEM_AW), .CNT_W(CNT_W)) u_dma (
    .clk, .rst,
    .wr_txa (wr_acc && (idx == IXW'(IX_TXA))),
    .wr_txn (wr_acc && (idx == IXW'(IX_TXN))),
    .wr_rxa (wr_acc && (idx == IXW'(IX_RXA))),
    .wr_rxn (wr_acc && (idx == IXW'(IX_RXN))),
    .wr_data(wr_acc && (idx == IXW'(IX_DATA))),
    .wdata  (bus_wdata),
    .bus_active(bus_req),
    .f_empty, .f_full, .f_head, .f_push, .f_din, .f_pop(f_pop_eng),
    .rx_valid, .rx_data, .rx_ready,
    .tx_valid, .tx_data, .tx_ready,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack,
    .busy(eng_busy), .tx_addr, .rx_addr, .rx_left
  );

  always_ff @(posedge clk) begin
    if (rst) ien_q <= '0;
    else if (wr_acc && (idx == IXW'(IX_IEN))) ien_q <= bus_wdata[STAT_W-1:0];
  end

  assign status = {rx_left == '0, 1'b1, !f_empty};

  sdp_irq #(.N(STAT_W)) u_irq (
    .clk, .rst, .status, .enable(ien_q), .irq
  );

  always_comb begin
    rd_val = '0;
    case (idx)
      IXW'(IX_ID):   rd_val = PORT_ID;
      IXW'(IX_DATA): rd_val = f_empty ? 32'hFFFF_FFFF : {24'd0, f_head};
      IXW'(IX_FCNT): rd_val = 32'(f_count);
      IXW'(IX_IEN):  rd_val = 32'(ien_q);
      IXW'(IX_TXA):  rd_val = 32'(tx_addr);
      IXW'(IX_RXA):  rd_val = 32'(rx_addr);
      IXW'(IX_RXN):  rd_val = 32'(rx_left);
      default:       rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_val;
  end

  a_r10_stall_busy: assert property (@(posedge clk) disable iff (rst)
    (bus_req && eng_busy) |-> bus_wait);
  a_r1_id_value: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && (idx == IXW'(IX_ID))) |=> (bus_rdata == PORT_ID));
  a_r2_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && (idx == IXW'(IX_DATA)) && f_empty) |=> (bus_rdata == 32'hFFFF_FFFF));
  a_r8_no_bus_pop_busy: assert property (@(posedge clk) disable iff (rst)
    f_pop_eng |-> !f_pop_bus);
endmodule

// File: tb/test_serial_dma_port.sv
`timescale 1ns/1ps
module test_serial_dma_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_wait;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_ready;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        irq;

  int nchk = 0, nfail = 0;
  int tx_n;
  logic [7:0] tx_log [0:1023];
  logic [7:0] wmem [0:255];
  logic [7:0] exp_mem [0:255];
  logic [7:0] q [$];
  logic [31:0] rxa_m, rxl_m;
  logic [2:0]  ien_m;

  always #4 clk = ~clk;

  serial_dma_port i_serial_dma_port (
    .clk, .rst, .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .bus_wait,
    .tx_data, .tx_valid, .tx_ready, .rx_data, .rx_valid, .rx_ready,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack, .irq
  );

  function automatic logic [7:0] rom_byte(input logic [7:0] a);
    return a * 8'd37 + 8'd11;
  endfunction

  assign mem_rdata = rom_byte(mem_addr[7:0]);

  always @(posedge clk) if (mem_req && mem_we && mem_ack) wmem[mem_addr[7:0]] <= mem_wdata;

  always @(posedge clk) begin
    if (rst) tx_n <= 0;
    else if (tx_valid && tx_ready) begin
      tx_log[tx_n[9:0]] <= tx_data;
      tx_n <= tx_n + 1;
    end
  end

  always @(negedge clk) begin
    tx_ready <= ($urandom % 3) != 0;
    mem_ack  <= ($urandom % 3) != 0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int ix, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'(ix << 2); bus_wdata = d;
    #1;
    while (bus_wait) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input int ix, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'(ix << 2);
    #1;
    while (bus_wait) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #1;
    while (!rx_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    rx_valid = 1'b0;
    if (rxl_m == 0) q.push_back(b);
    else begin
      exp_mem[rxa_m[7:0]] = b;
      rxa_m++;
      rxl_m--;
    end
  endtask

  task automatic wait_tx(input int target);
    for (int g = 0; g < 3000 && tx_n < target; g++) @(negedge clk);
  endtask

  function automatic logic exp_irq();
    logic [2:0] st;
    st = {rxl_m == 0, 1'b1, q.size() != 0};
    return |(st & ien_m);
  endfunction

  task automatic set_ien_chk(input logic [31:0] v, input string tag);
    bus_wr(3, v);
    ien_m = v[2:0];
    repeat (2) @(negedge clk);
    chk(tag, {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, base;
    void'($urandom(32'd2718));
    rxa_m = 0; rxl_m = 0; ien_m = 0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq", {31'd0, irq}, 32'd0);
    chk("R11 tx_valid", {31'd0, tx_valid}, 32'd0);
    chk("R11 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R11 rx_ready", {31'd0, rx_ready}, 32'd1);
    bus_rd(2, d); chk("R11 fifo count", d, 0);
    bus_rd(3, d); chk("R11 enable", d, 0);
    bus_rd(4, d); chk("R11 tx addr", d, 0);
    bus_rd(6, d); chk("R11 rx addr", d, 0);
    bus_rd(7, d); chk("R11 rx count", d, 0);

    // R1 constant, write-only count and unmapped reads
    bus_rd(0, d); chk("R1 id", d, 32'hC51D0001);
    bus_rd(5, d); chk("R1 tx count reads zero", d, 0);
    bus_rd(9, d); chk("R1 unmapped 9", d, 0);
    bus_rd(1023, d); chk("R1 unmapped top", d, 0);

    // R2 empty read
    bus_rd(1, d); chk("R2 empty data read", d, 32'hFFFF_FFFF);
    bus_rd(2, d); chk("R2 empty read pops nothing", d, 0);

    // R5 enable masking, R6 interrupt per bit
    bus_wr(3, 32'hFFFF_FFF8); bus_rd(3, d); chk("R5 upper bits dropped", d, 0);
    set_ien_chk(32'hFFFF_FFFF, "R6 all enabled");
    bus_rd(3, d); chk("R5 enable readback", d, 7);
    set_ien_chk(1, "R6 fifo bit empty");
    set_ien_chk(2, "R6 tx done bit");
    set_ien_chk(4, "R6 rx done bit");

    // R3 direct character write
    base = tx_n;
    bus_wr(1, 32'hDEAD_BEA5);
    wait_tx(base + 1);
    chk("R3 tx count", tx_n, base + 1);
    chk("R3 tx low byte", {24'd0, tx_log[base[9:0]]}, 32'hA5);

    // random mix of FIFO activity
    for (int i = 0; i < 240; i++) begin
      int op;
      op = $urandom % 5;
      case (op)
        0, 1: begin
          if (q.size() < 16) send_rx(8'($urandom));
          else begin
            @(negedge clk); rx_valid = 1'b1; rx_data = 8'h5A; #1;
            chk("R4 full blocks rx", {31'd0, rx_ready}, 0);
            @(negedge clk); rx_valid = 1'b0;
          end
        end
        2: begin
          logic [31:0] e;
          e = (q.size() != 0) ? {24'd0, q.pop_front()} : 32'hFFFF_FFFF;
          bus_rd(1, d); chk("R2 data pop", d, e);
        end
        3: begin
          bus_rd(2, d); chk("R4 occupancy", d, 32'(q.size()));
        end
        default: set_ien_chk($urandom, "R6 random enable");
      endcase
    end

    // R4 exact depth
    while (q.size() < 16) send_rx(8'($urandom));
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'hC3; #1;
    chk("R4 ready low at depth", {31'd0, rx_ready}, 0);
    @(negedge clk); rx_valid = 1'b0;
    bus_rd(2, d); chk("R4 count at depth", d, 16);

    // R8 drain smaller than occupancy
    bus_wr(6, 32'h40); rxa_m = 32'h40;
    bus_wr(7, 5);
    for (int k = 0; k < 5; k++) begin exp_mem[rxa_m[7:0]] = q.pop_front(); rxa_m++; end
    bus_rd(7, d); chk("R8 remaining after short drain", d, 0);
    bus_rd(2, d); chk("R8 fifo after short drain", d, 11);
    bus_rd(6, d); chk("R8 rx addr after short drain", d, 32'h45);
    for (int k = 32'h40; k < 32'h45; k++)
      chk("R8 drained byte", {24'd0, wmem[k]}, {24'd0, exp_mem[k]});

    // R8 drain larger than occupancy
    bus_wr(7, 20);
    n = q.size();
    for (int k = 0; k < n; k++) begin exp_mem[rxa_m[7:0]] = q.pop_front(); rxa_m++; end
    rxl_m = 32'(20 - n);
    bus_rd(7, d); chk("R8 remaining after long drain", d, 9);
    bus_rd(2, d); chk("R8 fifo empty after long drain", d, 0);
    bus_rd(6, d); chk("R8 rx addr after long drain", d, 32'h50);
    for (int k = 32'h45; k < 32'h50; k++)
      chk("R8 drained byte", {24'd0, wmem[k]}, {24'd0, exp_mem[k]});
    set_ien_chk(4, "R6 rx pending keeps bit clear");

    // R9 bypass
    for (int k = 0; k < 3; k++) send_rx(8'(8'h70 + k));
    repeat (4) @(negedge clk);
    bus_rd(2, d); chk("R9 fifo untouched", d, 0);
    bus_rd(7, d); chk("R9 count decremented", d, 6);
    for (int k = 0; k < 6; k++) send_rx(8'(8'h90 + k));
    repeat (4) @(negedge clk);
    bus_rd(7, d); chk("R9 count exhausted", d, 0);
    bus_rd(6, d); chk("R9 rx addr advanced", d, 32'h59);
    for (int k = 32'h50; k < 32'h59; k++)
      chk("R9 direct byte", {24'd0, wmem[k]}, {24'd0, exp_mem[k]});
    set_ien_chk(4, "R6 rx done bit set");
    send_rx(8'hEE);
    bus_rd(2, d); chk("R9 back to fifo", d, 1);

    // R7 transmit DMA with R10 stall
    base = tx_n;
    bus_wr(4, 32'h80);
    bus_wr(5, 12);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'(4 << 2); #1;
    chk("R10 wait during dma", {31'd0, bus_wait}, 1);
    while (bus_wait) begin @(negedge clk); #1; end
    @(posedge clk); #1; bus_req = 1'b0;
    chk("R7 tx addr final", bus_rdata, 32'h8C);
    wait_tx(base + 12);
    chk("R7 tx byte total", tx_n, base + 12);
    for (int k = 0; k < 12; k++)
      chk("R7 tx byte order", {24'd0, tx_log[10'(base + k)]}, {24'd0, rom_byte(8'(8'h80 + k))});

    // R10 write stalled behind DMA takes effect
    base = tx_n;
    bus_wr(4, 32'h90);
    bus_wr(5, 4);
    bus_wr(3, 3); ien_m = 3;
    bus_rd(3, d); chk("R10 stalled write lands", d, 3);
    bus_rd(4, d); chk("R7 second tx addr", d, 32'h94);
    wait_tx(base + 4);
    for (int k = 0; k < 4; k++)
      chk("R7 second tx order", {24'd0, tx_log[10'(base + k)]}, {24'd0, rom_byte(8'(8'h90 + k))});

    // R7 zero length
    base = tx_n;
    bus_wr(5, 0);
    repeat (20) @(negedge clk);
    chk("R7 zero length sends none", tx_n, base);
    bus_rd(4, d); chk("R7 zero length addr", d, 32'h94);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule